// File: doc/BRIEF.md
# Paged Register Access Sequencer

This block sits on the host side of a management bus and turns one request into the series of 16-bit register transfers that a paged switch register file expects behind a single management address. A request names a page, a register offset inside that page, an access width (8, 16, 32, 48 or 64 bits), a direction and, for writes, the data. The sequencer drives a register-level management master port with a request/acknowledge handshake. Each transfer carries a PHY address, a 5-bit register number, a direction and 16 bits of data. The serial master behind that port is not part of the block.

The sequencer remembers the last page it selected, so a run of accesses to one page selects it only once. It starts the access through a command register and polls that register until the busy bits clear. Polls are spaced by a programmable idle gap, and the number of polls is bounded, so an access that never completes ends in an error. It then gathers read data from a row of 16-bit data windows. An error reported on any transfer ends the request at once and forgets the cached page. Each request ends with a one-cycle completion pulse that carries the read data and an error flag.

Top module: `paged_reg_seq`

## Requirements
- R1: The page register (register 0x10) is written with the page in bits 15:8 and value 0x01 in bits 7:0 only when the requested page differs from the cached page. A successful page write loads the cache, and later requests to the same page issue no page write.
- R2: After reset the cache is marked unused and reads as 0xFF, so the first request writes the page register even when it asks for page 0xFF.
- R3: The width code on req_width is 0=8, 1=16, 2=32, 3=48, 4=64 bits, and it needs 1, 1, 2, 3 or 4 data windows. A write first stores its data into windows 0x18, 0x19, … in that order, with bits 16i+15:16i going to window i. The page write (if needed) and then the command write follow.
- R4: The command register (register 0x11) is written with the offset in bits 15:8 and an operation code in bits 1:0. The code is 01 for a write and 10 for a read, and bits 7:2 are zero.
- R5: After the command write, register 0x11 is read until bits 1:0 read 00. Other bits are ignored. If they are still nonzero on the fifth read, the request ends with the error flag set and no data window is read.
- R6: Between a busy poll and the next poll, the port is idle for exactly POLL_GAP cycles.
- R7: After a read completes, the needed windows are read in ascending order and window i lands in done_rdata bits 16i+15:16i. An 8-bit read returns only bits 7:0 of window 0x18. Unused bits, writes and failed requests return zero.
- R8: A transfer acknowledged with mm_err ends the request at once: no further transfer is issued, and done with done_err rises in the next cycle.
- R9: Any failed request marks the page cache unused, so the next request writes the page register again.
- R10: req_ready is high only while idle. A request is taken only when req_valid and req_ready are both high, and a request presented while busy has no effect. done is a one-cycle pulse.
- R11: Every transfer uses PHY address PHY_ADDR (default 0x1E). mm_req stays high with stable register number, direction and data until mm_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_page | input | PAGE_W | Page of the target register |
| req_offset | input | 8 | Register offset inside the page |
| req_width | input | 3 | Access width code (R3) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16*WIN_MAX | Write data, low bits first |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Request failed (valid with done) |
| done_rdata | output | 16*WIN_MAX | Assembled read data (valid with done) |
| mm_req | output | 1 | Transfer request to management master |
| mm_write | output | 1 | Transfer direction, 1 = write |
| mm_phy | output | 5 | PHY address of transfer |
| mm_reg | output | 5 | Register number of transfer |
| mm_wdata | output | 16 | Write data of transfer |
| mm_ack | input | 1 | Transfer finished (one cycle) |
| mm_err | input | 1 | Transfer failed (valid with mm_ack) |
| mm_rdata | input | 16 | Read data of transfer (valid with mm_ack) |

## Verification
A request is taken at the first clock edge where req_valid meets req_ready. Each transfer ends on its acknowledge cycle, and the next transfer is requested in the following cycle, except after a busy poll. After a busy poll the gap of POLL_GAP idle cycles comes first, so two consecutive poll acknowledges from the bench's fixed-latency master lie POLL_GAP+latency+2 cycles apart. The completion pulse, with its data and error flag, comes one cycle after the last acknowledge. The bench logs every transfer and its cycle inside its master model, waits for done at falling edges with a bound, and only then compares the log, the poll spacing, the flag and the data against a sequence it builds itself from the requirements and its own page-cache model.

// File: rtl/prs_pkg.sv
package prs_pkg;

   // register numbers seen by the paged register file
   localparam logic [4:0] REG_PAGE = 5'h10;
   localparam logic [4:0] REG_CMD  = 5'h11;
   localparam logic [4:0] REG_WIN0 = 5'h18;

   typedef enum logic [2:0] {
      ACC_W8  = 3'd0,
      ACC_W16 = 3'd1,
      ACC_W32 = 3'd2,
      ACC_W48 = 3'd3,
      ACC_W64 = 3'd4
   } acc_width_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_WDATA,
      S_PAGE,
      S_CMD,
      S_POLL,
      S_GAP,
      S_RDATA,
      S_DONE
   } seq_state_e;

   // number of 16-bit windows an access width needs
   function automatic int win_count(input logic [2:0] w);
      case (w)
         ACC_W8:  return 1;
         ACC_W16: return 1;
         ACC_W32: return 2;
         ACC_W48: return 3;
         default: return 4;
      endcase
   endfunction

endpackage

// File: rtl/prs_page_cache.sv
module prs_page_cache #(
   parameter int PAGE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PAGE_W-1:0] probe_page,
   input  logic              load,
   input  logic [PAGE_W-1:0] load_page,
   input  logic              inval,
   output logic              hit
);

   logic              used_q;
   logic [PAGE_W-1:0] page_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         used_q <= 1'b0;
         page_q <= '1;
      end else if (inval) begin
         used_q <= 1'b0;
         page_q <= '1;
      end else if (load) begin
         used_q <= 1'b1;
         page_q <= load_page;
      end
   end

   assign hit = used_q && (page_q == probe_page);

endmodule

// File: rtl/prs_gap_timer.sv
module prs_gap_timer #(
   parameter int GAP = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic expired
);

   localparam int CW = (GAP > 1) ? $clog2(GAP) : 1;

   generate
      if (GAP < 1) begin : g_bad_gap
         $error("prs_gap_timer: GAP must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= CW'(GAP - 1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/prs_rd_assembler.sv
module prs_rd_assembler #(
   parameter int WIN_MAX = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear,
   input  logic                 load,
   input  logic [$clog2(WIN_MAX)-1:0] idx,
   input  logic                 byte_only,
   input  logic [15:0]          win_data,
   output logic [16*WIN_MAX-1:0] data
);

   logic [15:0] win_q [WIN_MAX];

   generate
      for (genvar i = 0; i < WIN_MAX; i++) begin : g_win
         logic [15:0] fill;
         if (i == 0) begin : g_low
            assign fill = byte_only ? {8'h00, win_data[7:0]} : win_data;
         end else begin : g_high
            assign fill = win_data;
         end

         always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
               win_q[i] <= '0;
            end else if (load && (int'(idx) == i)) begin
               win_q[i] <= fill;
            end
         end

         assign data[16*i +: 16] = win_q[i];
      end
   endgenerate

endmodule

// File: rtl/paged_reg_seq.sv
module paged_reg_seq
   import prs_pkg::*;
#(
   parameter logic [4:0] PHY_ADDR   = 5'h1E,
   parameter int         PAGE_W     = 8,
   parameter int         WIN_MAX    = 4,
   parameter int         POLL_LIMIT = 5,
   parameter int         POLL_GAP   = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [PAGE_W-1:0]      req_page,
   input  logic [7:0]             req_offset,
   input  logic [2:0]             req_width,
   input  logic                   req_write,
   input  logic [16*WIN_MAX-1:0]  req_wdata,
   output logic                   done,
   output logic                   done_err,
   output logic [16*WIN_MAX-1:0]  done_rdata,
   output logic                   mm_req,
   output logic                   mm_write,
   output logic [4:0]             mm_phy,
   output logic [4:0]             mm_reg,
   output logic [15:0]            mm_wdata,
   input  logic                   mm_ack,
   input  logic                   mm_err,
   input  logic [15:0]            mm_rdata
);

   localparam int DATA_W = 16 * WIN_MAX;
   localparam int IW     = $clog2(WIN_MAX);
   localparam int PW     = $clog2(POLL_LIMIT + 1);

   generate
      if (PAGE_W < 1 || PAGE_W > 8) begin : g_bad_page
         $error("paged_reg_seq: PAGE_W must lie in 1..8");
      end
      if (WIN_MAX < 2 || WIN_MAX > 8) begin : g_bad_win
         $error("paged_reg_seq: WIN_MAX must lie in 2..8");
      end
      if (POLL_LIMIT < 1) begin : g_bad_limit
         $error("paged_reg_seq: POLL_LIMIT must be at least 1");
      end
   endgenerate

   function automatic logic [IW-1:0] last_index(input logic [2:0] w);
      int n;
      n = win_count(w);
      if (n > WIN_MAX) n = WIN_MAX;
      return IW'(n - 1);
   endfunction

   // captured request
   seq_state_e         st_q, st_nxt;
   logic [PAGE_W-1:0]  pg_q;
   logic [7:0]         off_q;
   logic               wr_q;
   logic               byte_q;
   logic [IW-1:0]      lastidx_q;
   logic [DATA_W-1:0]  wdata_q;
   logic [IW-1:0]      idx_q;
   logic [PW-1:0]      poll_q;
   logic               err_q;

   // control strobes
   logic take, idx_clr, idx_inc, poll_clr, poll_inc;
   logic gap_start, gap_expired, cache_load, set_fail, asm_load, hit;
   logic [PAGE_W-1:0] probe_page;
   logic [DATA_W-1:0] asm_data;
   logic [15:0]       wwin [WIN_MAX];
   logic              last_win;

   generate
      for (genvar i = 0; i < WIN_MAX; i++) begin : g_wslice
         assign wwin[i] = wdata_q[16*i +: 16];
      end
   endgenerate

   assign probe_page = (st_q == S_IDLE) ? req_page : pg_q;
   assign last_win   = (idx_q == lastidx_q);

   prs_page_cache #(.PAGE_W(PAGE_W)) u_cache (
      .clk        (clk),
      .rst_n      (rst_n),
      .probe_page (probe_page),
      .load       (cache_load),
      .load_page  (pg_q),
      .inval      (set_fail),
      .hit        (hit)
   );

   prs_gap_timer #(.GAP(POLL_GAP)) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (gap_start),
      .expired (gap_expired)
   );

   prs_rd_assembler #(.WIN_MAX(WIN_MAX)) u_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (take),
      .load      (asm_load),
      .idx       (idx_q),
      .byte_only (byte_q),
      .win_data  (mm_rdata),
      .data      (asm_data)
   );

   always_comb begin
      st_nxt     = st_q;
      mm_req     = 1'b0;
      mm_write   = 1'b0;
      mm_reg     = REG_PAGE;
      mm_wdata   = '0;
      take       = 1'b0;
      idx_clr    = 1'b0;
      idx_inc    = 1'b0;
      poll_clr   = 1'b0;
      poll_inc   = 1'b0;
      gap_start  = 1'b0;
      cache_load = 1'b0;
      set_fail   = 1'b0;
      asm_load   = 1'b0;
      unique case (st_q)
         S_IDLE: begin
            if (req_valid) begin
               take    = 1'b1;
               idx_clr = 1'b1;
               if (req_write) st_nxt = S_WDATA;
               else           st_nxt = hit ? S_CMD : S_PAGE;
            end
         end
         S_WDATA: begin
            mm_req   = 1'b1;
            mm_write = 1'b1;
            mm_reg   = REG_WIN0 + 5'(idx_q);
            mm_wdata = wwin[idx_q];
            if (mm_ack) begin
               if (mm_err)        set_fail = 1'b1;
               else if (last_win) st_nxt = hit ? S_CMD : S_PAGE;
               else               idx_inc = 1'b1;
            end
         end
         S_PAGE: begin
            mm_req   = 1'b1;
            mm_write = 1'b1;
            mm_reg   = REG_PAGE;
            mm_wdata = {8'(pg_q), 8'h01};
            if (mm_ack) begin
               if (mm_err) set_fail = 1'b1;
               else begin
                  cache_load = 1'b1;
                  st_nxt     = S_CMD;
               end
            end
         end
         S_CMD: begin
            mm_req   = 1'b1;
            mm_write = 1'b1;
            mm_reg   = REG_CMD;
            mm_wdata = {off_q, 6'b0, ~wr_q, wr_q};
            if (mm_ack) begin
               if (mm_err) set_fail = 1'b1;
               else begin
                  poll_clr = 1'b1;
                  st_nxt   = S_POLL;
               end
            end
         end
         S_POLL: begin
            mm_req = 1'b1;
            mm_reg = REG_CMD;
            if (mm_ack) begin
               if (mm_err) set_fail = 1'b1;
               else if (mm_rdata[1:0] == 2'b00) begin
                  if (wr_q) st_nxt = S_DONE;
                  else begin
                     idx_clr = 1'b1;
                     st_nxt  = S_RDATA;
                  end
               end else if (poll_q == PW'(POLL_LIMIT - 1)) begin
                  set_fail = 1'b1;
               end else begin
                  poll_inc  = 1'b1;
                  gap_start = 1'b1;
                  st_nxt    = S_GAP;
               end
            end
         end
         S_GAP: begin
            if (gap_expired) st_nxt = S_POLL;
         end
         S_RDATA: begin
            mm_req = 1'b1;
            mm_reg = REG_WIN0 + 5'(idx_q);
            if (mm_ack) begin
               if (mm_err) set_fail = 1'b1;
               else begin
                  asm_load = 1'b1;
                  if (last_win) st_nxt = S_DONE;
                  else          idx_inc = 1'b1;
               end
            end
         end
         S_DONE: st_nxt = S_IDLE;
         default: st_nxt = S_IDLE;
      endcase
      if (set_fail) st_nxt = S_DONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= S_IDLE;
         pg_q      <= '0;
         off_q     <= '0;
         wr_q      <= 1'b0;
         byte_q    <= 1'b0;
         lastidx_q <= '0;
         wdata_q   <= '0;
         idx_q     <= '0;
         poll_q    <= '0;
         err_q     <= 1'b0;
      end else begin
         st_q <= st_nxt;
         if (take) begin
            pg_q      <= req_page;
            off_q     <= req_offset;
            wr_q      <= req_write;
            byte_q    <= (req_width == ACC_W8);
            lastidx_q <= last_index(req_width);
            wdata_q   <= req_wdata;
            err_q     <= 1'b0;
         end
         if (idx_clr)      idx_q <= '0;
         else if (idx_inc) idx_q <= idx_q + 1'b1;
         if (poll_clr)      poll_q <= '0;
         else if (poll_inc) poll_q <= poll_q + 1'b1;
         if (set_fail) err_q <= 1'b1;
      end
   end

   assign mm_phy     = PHY_ADDR;
   assign req_ready  = (st_q == S_IDLE);
   assign done       = (st_q == S_DONE);
   assign done_err   = err_q;
   assign done_rdata = (err_q || wr_q) ? '0 : asm_data;

endmodule

// File: rtl/prs_checker.sv
module prs_checker
   import prs_pkg::*;
#(
   parameter logic [4:0] PHY_ADDR = 5'h1E,
   parameter int         WIN_MAX  = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic                  req_ready,
   input logic                  done,
   input logic                  done_err,
   input logic [16*WIN_MAX-1:0] done_rdata,
   input logic                  mm_req,
   input logic                  mm_write,
   input logic [4:0]            mm_phy,
   input logic [4:0]            mm_reg,
   input logic [15:0]           mm_wdata,
   input logic                  mm_ack,
   input logic                  mm_err
);

   // R11: transfer fields held until acknowledged
   p_hold_until_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mm_req && !mm_ack) |=> (mm_req && $stable(mm_reg) && $stable(mm_write) && $stable(mm_wdata)));

   // R11: fixed management address
   p_phy_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mm_req |-> (mm_phy == PHY_ADDR));

   // R1: page write format
   p_page_format_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mm_req && mm_write && mm_reg == REG_PAGE) |-> (mm_wdata[7:0] == 8'h01));

   // R4: command write carries exactly one op bit
   p_cmd_format_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mm_req && mm_write && mm_reg == REG_CMD) |->
         (mm_wdata[7:2] == 6'b0 && $countones(mm_wdata[1:0]) == 1));

   // R5: status register only read, never the data windows written after the command
   p_poll_is_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mm_req && !mm_write) |-> (mm_reg == REG_CMD || mm_reg >= REG_WIN0));

   // R8: error acknowledge finishes the request next cycle
   p_abort_on_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mm_req && mm_ack && mm_err) |=> (done && done_err && !mm_req));

   // R10: done is a single pulse followed by idle
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && req_ready));

   // R10: taking a request leaves idle
   p_take_leaves_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R10: no transfer while idle
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mm_req);

endmodule

bind paged_reg_seq prs_checker #(.PHY_ADDR(PHY_ADDR), .WIN_MAX(WIN_MAX)) u_chk (.*);

// File: tb/sim_paged_reg_seq.sv
`timescale 1ns/1ps
module sim_paged_reg_seq;

   localparam int GAP   = 6;
   localparam int LAT   = 2;
   localparam int LIMIT = 5;
   localparam logic [4:0] R_PAGE = 5'h10;
   localparam logic [4:0] R_CMD  = 5'h11;
   localparam logic [4:0] R_WIN  = 5'h18;

   typedef struct packed {
      logic [7:0]  page;
      logic [7:0]  off;
      logic [2:0]  wid;
      logic        wr;
      logic [63:0] wd;
      logic [3:0]  busy;
      logic [3:0]  erri;   // 15 = no injected error
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{8'h12, 8'h04, 3'd4, 1'b0, 64'h0, 4'd0, 4'd15},                  // R1 R7 miss, 64-bit read
      '{8'h12, 8'h08, 3'd2, 1'b1, 64'h0000_0000_BEEF_1234, 4'd1, 4'd15}, // R1 R3 hit, 32-bit write
      '{8'h12, 8'h2C, 3'd0, 1'b0, 64'h0, 4'd2, 4'd15},                  // R7 8-bit read
      '{8'h34, 8'h10, 3'd3, 1'b1, 64'h0000_A1A2_B3B4_C5C6, 4'd0, 4'd15}, // R3 48-bit write, miss
      '{8'h34, 8'h20, 3'd1, 1'b0, 64'h0, 4'd4, 4'd15},                  // R5 fifth poll clears
      '{8'h34, 8'h24, 3'd2, 1'b0, 64'h0, 4'd5, 4'd15},                  // R5 never clears
      '{8'h34, 8'h28, 3'd2, 1'b0, 64'h0, 4'd0, 4'd15},                  // R9 page rewritten
      '{8'h00, 8'h30, 3'd4, 1'b1, 64'h1111_2222_3333_4444, 4'd0, 4'd1},  // R8 error on 2nd window
      '{8'h00, 8'h34, 3'd1, 1'b1, 64'h0000_0000_0000_5A5A, 4'd0, 4'd15}, // R3 16-bit write
      '{8'h00, 8'h38, 3'd3, 1'b0, 64'h0, 4'd3, 4'd15},                  // R7 48-bit read, hit
      '{8'h00, 8'h3C, 3'd1, 1'b0, 64'h0, 4'd0, 4'd1},                   // R8 error on poll
      '{8'h00, 8'h40, 3'd0, 1'b0, 64'h0, 4'd0, 4'd15}                   // R9 page rewritten
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [7:0]  req_page = '0;
   logic [7:0]  req_offset = '0;
   logic [2:0]  req_width = '0;
   logic        req_write = 1'b0;
   logic [63:0] req_wdata = '0;
   logic        done, done_err;
   logic [63:0] done_rdata;
   logic        mm_req, mm_write;
   logic [4:0]  mm_phy, mm_reg;
   logic [15:0] mm_wdata;
   logic        mm_ack = 1'b0;
   logic        mm_err = 1'b0;
   logic [15:0] mm_rdata = '0;

   always #10 clk = ~clk;

   paged_reg_seq #(.POLL_GAP(GAP), .POLL_LIMIT(LIMIT)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_page(req_page), .req_offset(req_offset), .req_width(req_width),
      .req_write(req_write), .req_wdata(req_wdata),
      .done(done), .done_err(done_err), .done_rdata(done_rdata),
      .mm_req(mm_req), .mm_write(mm_write), .mm_phy(mm_phy), .mm_reg(mm_reg),
      .mm_wdata(mm_wdata), .mm_ack(mm_ack), .mm_err(mm_err), .mm_rdata(mm_rdata)
   );

   // ---------------- management master model ----------------
   int          cyc = 0;
   int          wcnt = 0;
   int          log_n = 0;
   int          polls_seen = 0;
   logic [1:0]  last_op = 2'b00;
   logic [7:0]  cur_off = '0;
   int          cur_busy = 0;
   int          cur_erri = 15;
   logic [4:0]  log_reg [32];
   logic        log_wr  [32];
   logic [15:0] log_dat [32];
   logic [4:0]  log_phy [32];
   int          log_cyc [32];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (req_valid && req_ready) begin
         log_n      <= 0;
         polls_seen <= 0;
         cur_off    <= req_offset;
      end
      if (mm_ack) begin
         mm_ack <= 1'b0;
         mm_err <= 1'b0;
      end else if (mm_req) begin
         if (wcnt == LAT) begin
            wcnt   <= 0;
            mm_ack <= 1'b1;
            mm_err <= (log_n == cur_erri);
            if (log_n < 32) begin
               log_reg[log_n] <= mm_reg;
               log_wr[log_n]  <= mm_write;
               log_dat[log_n] <= mm_wdata;
               log_phy[log_n] <= mm_phy;
               log_cyc[log_n] <= cyc;
            end
            log_n <= log_n + 1;
            if (mm_write) begin
               mm_rdata <= 16'h0;
               if (mm_reg == R_CMD) last_op <= mm_wdata[1:0];
            end else if (mm_reg == R_CMD) begin
               mm_rdata   <= (polls_seen < cur_busy) ? {14'h0, last_op} : 16'hFFFC;
               polls_seen <= polls_seen + 1;
            end else begin
               mm_rdata <= {cur_off, 8'hC0 + {3'b0, mm_reg - R_WIN}};
            end
         end else begin
            wcnt <= wcnt + 1;
         end
      end
   end

   // ---------------- checking ----------------
   int total = 0;
   int bad = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // bench page-cache model
   bit          bc_used = 1'b0;
   logic [7:0]  bc_page = 8'hFF;
   logic [4:0]  exp_reg [16];
   logic        exp_wr  [16];
   logic [15:0] exp_dat [16];
   int          exp_n;
   bit          exp_err;
   logic [63:0] exp_rd;

   function automatic int nwin(input logic [2:0] w);
      case (w)
         3'd0, 3'd1: return 1;
         3'd2:       return 2;
         3'd3:       return 3;
         default:    return 4;
      endcase
   endfunction

   task automatic push(input logic [4:0] r, input logic w, input logic [15:0] d);
      exp_reg[exp_n] = r;
      exp_wr[exp_n]  = w;
      exp_dat[exp_n] = d;
      exp_n++;
   endtask

   task automatic build_exp(input vec_t v);
      int  nw;
      int  np;
      bit  ok;
      nw    = nwin(v.wid);
      exp_n = 0;
      if (v.wr) for (int i = 0; i < nw; i++) push(R_WIN + 5'(i), 1'b1, v.wd[16*i +: 16]);
      if (!(bc_used && bc_page == v.page)) push(R_PAGE, 1'b1, {v.page, 8'h01});
      push(R_CMD, 1'b1, {v.off, 6'b0, ~v.wr, v.wr});
      ok = (int'(v.busy) < LIMIT);
      np = ok ? int'(v.busy) + 1 : LIMIT;
      for (int i = 0; i < np; i++) push(R_CMD, 1'b0, 16'h0);
      if (ok && !v.wr) for (int i = 0; i < nw; i++) push(R_WIN + 5'(i), 1'b0, 16'h0);
      if (v.erri != 4'd15 && int'(v.erri) < exp_n) begin
         exp_n   = int'(v.erri) + 1;
         exp_err = 1'b1;
      end else begin
         exp_err = !ok;
      end
      exp_rd = '0;
      if (!exp_err && !v.wr) begin
         for (int i = 0; i < nw; i++) exp_rd[16*i +: 16] = {v.off, 8'hC0 + 8'(i)};
         if (v.wid == 3'd0) exp_rd = {56'h0, 8'hC0};
      end
      if (exp_err) begin
         bc_used = 1'b0;
         bc_page = 8'hFF;
      end else begin
         bc_used = 1'b1;
         bc_page = v.page;
      end
   endtask

   task automatic run_vec(input vec_t v, input int id);
      bit          seen;
      bit          got_err;
      logic [63:0] got_rd;
      bit          seq_ok;
      int          bad_i;
      bit          gap_ok;
      int          gap_act;
      build_exp(v);
      @(negedge clk);
      cur_busy   = int'(v.busy);
      cur_erri   = int'(v.erri);
      req_page   = v.page;
      req_offset = v.off;
      req_width  = v.wid;
      req_write  = v.wr;
      req_wdata  = v.wd;
      req_valid  = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      seen = 1'b0;
      got_err = 1'b0;
      got_rd = '0;
      for (int t = 0; t < 2000 && !seen; t++) begin
         if (done) begin
            seen    = 1'b1;
            got_err = done_err;
            got_rd  = done_rdata;
         end else @(negedge clk);
      end
      chk(seen, "R10", $sformatf("vec %0d done pulse", id), 64'(seen), 64'd1);
      chk(log_n == exp_n, "R3/R5 R8", $sformatf("vec %0d transfer count", id), 64'(log_n), 64'(exp_n));
      seq_ok = 1'b1;
      bad_i  = 0;
      for (int i = 0; i < exp_n && i < log_n; i++) begin
         if (seq_ok && (log_reg[i] != exp_reg[i] || log_wr[i] != exp_wr[i] ||
                        log_phy[i] != 5'h1E || (exp_wr[i] && log_dat[i] != exp_dat[i]))) begin
            seq_ok = 1'b0;
            bad_i  = i;
         end
      end
      // R1 R3 R4 R11: order, registers and data of every transfer
      chk(seq_ok, "R1 R3 R4 R11", $sformatf("vec %0d transfer %0d", id, bad_i),
          {42'h0, log_phy[bad_i], log_reg[bad_i], log_wr[bad_i], log_dat[bad_i]},
          {42'h0, 5'h1E, exp_reg[bad_i], exp_wr[bad_i], exp_dat[bad_i]});
      chk(got_err == exp_err, "R5 R8", $sformatf("vec %0d error flag", id), 64'(got_err), 64'(exp_err));
      chk(got_rd == exp_rd, "R7", $sformatf("vec %0d read data", id), got_rd, exp_rd);
      // R6: spacing of consecutive status polls
      gap_ok  = 1'b1;
      gap_act = GAP + LAT + 2;
      for (int i = 1; i < log_n && i < 32; i++) begin
         if (!log_wr[i] && !log_wr[i-1] && log_reg[i] == R_CMD && log_reg[i-1] == R_CMD &&
             (log_cyc[i] - log_cyc[i-1]) != GAP + LAT + 2) begin
            gap_ok  = 1'b0;
            gap_act = log_cyc[i] - log_cyc[i-1];
         end
      end
      chk(gap_ok, "R6", $sformatf("vec %0d poll spacing", id), 64'(gap_act), 64'(GAP + LAT + 2));
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n   = 1'b1;
      bc_used = 1'b0;
      bc_page = 8'hFF;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int done_cnt;
      int n_before;
      vec_t v;
      do_reset();
      // R10 R11: reset state
      chk(req_ready == 1'b1, "R10", "reset ready", 64'(req_ready), 64'd1);
      chk(done == 1'b0, "R10", "reset done", 64'(done), 64'd0);
      chk(mm_req == 1'b0, "R11", "reset mm_req", 64'(mm_req), 64'd0);

      for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

      // R2: page 0xFF after reset still writes the page register
      do_reset();
      v = '{8'hFF, 8'h02, 3'd1, 1'b0, 64'h0, 4'd0, 4'd15};
      run_vec(v, 100);
      chk(log_reg[0] == R_PAGE, "R2", "first transfer after reset", 64'(log_reg[0]), 64'(R_PAGE));
      // R1: same page again skips the page write
      v = '{8'hFF, 8'h06, 3'd1, 1'b0, 64'h0, 4'd0, 4'd15};
      run_vec(v, 101);
      chk(log_reg[0] == R_CMD, "R1", "cached page skips page write", 64'(log_reg[0]), 64'(R_CMD));

      // R10: request presented while busy is ignored
      v = '{8'hFF, 8'h0A, 3'd2, 1'b0, 64'h0, 4'd1, 4'd15};
      build_exp(v);
      @(negedge clk);
      cur_busy = 1; cur_erri = 15;
      req_page = v.page; req_offset = v.off; req_width = v.wid; req_write = 1'b0;
      req_valid = 1'b1;
      @(negedge clk);
      req_page = 8'h77; req_offset = 8'h55; req_write = 1'b1;
      done_cnt = 0;
      for (int t = 0; t < 2000 && done_cnt == 0; t++) begin
         if (done) begin
            done_cnt++;
            req_valid = 1'b0;
         end else @(negedge clk);
      end
      n_before = log_n;
      repeat (30) begin
         @(negedge clk);
         if (done) done_cnt++;
      end
      chk(done_cnt == 1, "R10", "busy request ignored, done count", 64'(done_cnt), 64'd1);
      chk(n_before == exp_n && log_n == exp_n, "R10", "busy request ignored, transfers",
          64'(log_n), 64'(exp_n));

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule